// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This block watches a load/store bus for accesses to chosen data addresses. It holds a set of identical watch slots. Each slot has a full-width compare value, a mask size and a function word. On every valid bus access, each slot ignores the number of low address bits that its mask size selects. It then compares the remaining address with its compare value and checks the access direction against its function code. A slot that fires sets a sticky matched flag. The unit then raises a debug event for one cycle, together with a vector that names the slots that fired.

Software or a debugger reaches the slots through a simple register port. The register address holds a slot index in its upper bits and a register select in its two low bits. Read data is combinational and follows the register address. Reading a slot's function word with the read strobe high returns the word as it stands in that cycle, then clears the matched flag at the clock edge. The flag stays set if the slot fires in that same cycle.

Top module: `addr_watch_unit`

## Requirements
- R1: A slot matches a valid access when (bus_addr AND (all-ones shifted left by mask size)) equals its compare value exactly. A compare value with bits set below the mask therefore never matches.
- R2: Function code bits [3:0] select the direction: 4'b0101 watches reads (bus_write=0), 4'b0110 watches writes (bus_write=1) and 4'b0111 watches both. 4'b0000 and every other code disable the slot.
- R3: No slot fires in a cycle where bus_valid is low.
- R4: A firing slot sets bit 24 of its function word, and the bit stays set across later accesses that do not fire.
- R5: A read strobe on register select 2 returns the function word with the flag as it was in that cycle, and the flag reads 0 from the next cycle on.
- R6: If a slot fires in the same cycle as a read of its function word, the read returns the old flag and the flag stays set afterwards.
- R7: hit_vec and dbg_event are registered. In the cycle after a clock edge that samples a firing access, hit_vec bit i is 1 for each slot i that fired and dbg_event is 1 if any slot fired. Both are 0 otherwise.
- R8: Function word bits [11:10] store a size code (00 byte, 01 halfword, 10 word). A write carrying 11 leaves the stored size unchanged, while the function code in the same write still takes effect.
- R9: In the function word, bit 9 and all bits other than [3:0], [11:10] and 24 read 0. Register select 3 reads 0, and a write to it has no effect.
- R10: After reset every function code is disabled, every matched flag is clear, and compare, mask and size read 0.
- R11: Register select 0 reads back the full compare value. Register select 1 reads back the 4-bit mask size in bits [3:0], with 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | Access direction, 1 = write |
| bus_addr | input | ADDR_W | Access address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a matched flag on a function-word read) |
| reg_addr | input | RA_W | {slot index, register select}; select 0 compare, 1 mask, 2 function, 3 reserved |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Combinational read data for reg_addr |
| hit_vec | output | NUM_SLOTS | Slots that fired on the previous edge |
| dbg_event | output | 1 | One cycle per firing edge, any slot |

## Verification
The bench builds the unit with its defaults: four slots, 32-bit addresses and a 4-bit mask size, so the register address is four bits wide. With four slots, one test pattern can program the read, write, both-direction and unlisted function codes side by side, and the same access can then fire some slots and not others in a single cycle. The full 4-bit mask range lets the bench reach the zero mask and the fifteen-bit mask. It can also reach a compare value that has bits below its mask. Under this setup the simultaneous read-and-fire case and the ignored size code can each be aimed at a single slot.

// File: rtl/awu_pkg.sv
// Package: shared register-select codes, function codes and helpers for
// the address watch unit. Assumes at most a few dozen slots.
package awu_pkg;

    typedef enum logic [1:0] {
        SEL_CMP  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FUNC = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    localparam logic [3:0] FN_OFF   = 4'b0000;
    localparam logic [3:0] FN_READ  = 4'b0101;
    localparam logic [3:0] FN_WRITE = 4'b0110;
    localparam logic [3:0] FN_BOTH  = 4'b0111;

    localparam logic [1:0] SIZE_BAD = 2'b11;

    localparam int FLAG_BIT = 24;
    localparam int SIZE_LO  = 10;

    // Width of a slot index, at least one bit.
    function automatic int slot_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // True when a function code watches the given direction.
    function automatic logic dir_ok(input logic [3:0] fn, input logic is_wr);
        case (fn)
            FN_READ:  return !is_wr;
            FN_WRITE: return is_wr;
            FN_BOTH:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/awu_decode.sv
// Register-port decoder: splits the register address into slot index and
// register select and produces one-hot per-slot strobes. Assumes reg_addr
// is {slot, select[1:0]}; slot indices beyond NUM_SLOTS select nothing.
module awu_decode #(
    parameter int NUM_SLOTS = 4,
    parameter int RA_W      = 4
) (
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [RA_W-1:0]      reg_addr,
    output logic [NUM_SLOTS-1:0] wr_cmp,
    output logic [NUM_SLOTS-1:0] wr_mask,
    output logic [NUM_SLOTS-1:0] wr_func,
    output logic [NUM_SLOTS-1:0] rd_func
);
    import awu_pkg::*;

    logic [RA_W-3:0] slot_idx;
    logic [1:0]      sel;

    assign slot_idx = reg_addr[RA_W-1:2];
    assign sel      = reg_addr[1:0];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_strobe
        logic here;
        // Slot g is addressed when the index field equals g.
        assign here       = (slot_idx == (RA_W-2)'(g));
        assign wr_cmp[g]  = here && reg_wr && (sel == SEL_CMP);
        assign wr_mask[g] = here && reg_wr && (sel == SEL_MASK);
        assign wr_func[g] = here && reg_wr && (sel == SEL_FUNC);
        assign rd_func[g] = here && reg_rd && (sel == SEL_FUNC);
    end

endmodule

// File: rtl/awu_slot.sv
// One watch slot: compare, mask size, function code, size code and the
// sticky matched flag, plus the combinational match for the current bus
// access. Assumes ADDR_W >= 25 so the flag bit fits in the function word.
module awu_slot #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmp,
    input  logic              wr_mask,
    input  logic              wr_func,
    input  logic              rd_func,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] cmp_word,
    output logic [ADDR_W-1:0] mask_word,
    output logic [ADDR_W-1:0] func_word,
    output logic              match,
    output logic              flag
);
    import awu_pkg::*;

    logic [ADDR_W-1:0] cmp_q;
    logic [MASK_W-1:0] mask_q;
    logic [3:0]        fn_q;
    logic [1:0]        size_q;
    logic              flag_q;
    logic [ADDR_W-1:0] keep_bits;

    // Compare register: written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
    end

    // Mask-size register: low MASK_W bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata[MASK_W-1:0];
    end

    // Function code and size code; the forbidden size code is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q   <= FN_OFF;
            size_q <= 2'b00;
        end else if (wr_func) begin
            fn_q <= wdata[3:0];
            if (wdata[SIZE_LO+1:SIZE_LO] != SIZE_BAD)
                size_q <= wdata[SIZE_LO+1:SIZE_LO];
        end
    end

    // Address bits kept after dropping mask_q low bits.
    assign keep_bits = {ADDR_W{1'b1}} << mask_q;

    // Current access hits this slot.
    assign match = bus_valid && dir_ok(fn_q, bus_write)
                   && ((bus_addr & keep_bits) == cmp_q);

    // Sticky flag: a hit wins over a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (match)   flag_q <= 1'b1;
        else if (rd_func) flag_q <= 1'b0;
    end

    // Read-back words, unused bits zero.
    always_comb begin
        cmp_word  = cmp_q;
        mask_word = '0;
        mask_word[MASK_W-1:0] = mask_q;
        func_word = '0;
        func_word[3:0] = fn_q;
        func_word[SIZE_LO+1:SIZE_LO] = size_q;
        func_word[FLAG_BIT] = flag_q;
    end

    assign flag = flag_q;

endmodule

// File: rtl/addr_watch_unit.sv
// Top of the address watch unit: NUM_SLOTS watch slots behind a simple
// register port, a combinational read mux and registered hit outputs.
// Assumes a synchronous active-low reset and ADDR_W >= 25.
module addr_watch_unit #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int MASK_W    = 4,
    localparam int RA_W     = awu_pkg::slot_bits(NUM_SLOTS) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic [NUM_SLOTS-1:0] hit_vec,
    output logic                 dbg_event
);
    import awu_pkg::*;

    logic [NUM_SLOTS-1:0] wr_cmp, wr_mask, wr_func, rd_func;
    logic [NUM_SLOTS-1:0] match_vec;
    logic [NUM_SLOTS-1:0] flag_vec;
    logic [ADDR_W-1:0]    cmp_words  [NUM_SLOTS];
    logic [ADDR_W-1:0]    mask_words [NUM_SLOTS];
    logic [ADDR_W-1:0]    func_words [NUM_SLOTS];

    awu_decode #(.NUM_SLOTS(NUM_SLOTS), .RA_W(RA_W)) decode_i (
        .reg_wr  (reg_wr),
        .reg_rd  (reg_rd),
        .reg_addr(reg_addr),
        .wr_cmp  (wr_cmp),
        .wr_mask (wr_mask),
        .wr_func (wr_func),
        .rd_func (rd_func)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        awu_slot #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cmp   (wr_cmp[g]),
            .wr_mask  (wr_mask[g]),
            .wr_func  (wr_func[g]),
            .rd_func  (rd_func[g]),
            .wdata    (reg_wdata),
            .bus_valid(bus_valid),
            .bus_write(bus_write),
            .bus_addr (bus_addr),
            .cmp_word (cmp_words[g]),
            .mask_word(mask_words[g]),
            .func_word(func_words[g]),
            .match    (match_vec[g]),
            .flag     (flag_vec[g])
        );
    end

    // Read mux: slot by index field, register by select field.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (reg_addr[RA_W-1:2] == (RA_W-2)'(i)) begin
                case (reg_addr[1:0])
                    SEL_CMP:  reg_rdata = cmp_words[i];
                    SEL_MASK: reg_rdata = mask_words[i];
                    SEL_FUNC: reg_rdata = func_words[i];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

    // Registered hit vector and combined debug event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec   <= '0;
            dbg_event <= 1'b0;
        end else begin
            hit_vec   <= match_vec;
            dbg_event <= |match_vec;
        end
    end

endmodule

// File: rtl/awu_checker.sv
// Checker for the address watch unit: port- and flag-level properties,
// attached to every instance of the top through bind.
module awu_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int RA_W      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 reg_rd,
    input logic [RA_W-1:0]      reg_addr,
    input logic [ADDR_W-1:0]    reg_rdata,
    input logic [NUM_SLOTS-1:0] hit_vec,
    input logic                 dbg_event,
    input logic [NUM_SLOTS-1:0] flag_vec
);

    // R3: an event needs a valid access on the edge before.
    a_r3_event_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_event |-> $past(bus_valid));

    // R7: the event is high exactly when some slot is reported.
    a_r7_event_tracks_hits: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_event == (hit_vec != '0));

    // R4: every reported slot holds its matched flag.
    a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~flag_vec) == '0);

    // R5: a flag only drops after a function-word read.
    a_r5_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_vec) & ~flag_vec) != '0) |-> $past(reg_rd && reg_addr[1:0] == 2'd2));

    // R9: bit 9 of a function word reads 0.
    a_r9_link_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] == 2'd2) |-> (reg_rdata[9] == 1'b0));

    // R9: the reserved select reads 0.
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] == 2'd3) |-> (reg_rdata == '0));

endmodule

bind addr_watch_unit awu_checker #(
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),
    .RA_W     (RA_W)
) awu_checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .hit_vec  (hit_vec),
    .dbg_event(dbg_event),
    .flag_vec (flag_vec)
);

// File: tb/addr_watch_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the unit every clock.
module addr_watch_unit_tb_top;

    localparam int NS = 4;
    localparam int AW = 32;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [RW-1:0] reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic [NS-1:0] hit_vec;
    logic          dbg_event;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    addr_watch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit_vec(hit_vec),
        .dbg_event(dbg_event)
    );

    // Reference model state.
    int unsigned m_cmp [NS];
    int unsigned m_msk [NS];
    int unsigned m_fn  [NS];
    int unsigned m_sz  [NS];
    bit          m_flag[NS];
    bit [NS-1:0] m_hit;
    bit          m_ev;

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_cmp[i] = 0; m_msk[i] = 0; m_fn[i] = 0; m_sz[i] = 0; m_flag[i] = 0;
        end
        m_hit = '0; m_ev = 0;
    endtask

    function automatic int unsigned model_read(input int a);
        int s = a / 4;
        int r = a % 4;
        if (s >= NS) return 0;
        case (r)
            0: return m_cmp[s];
            1: return m_msk[s];
            2: return (int'(m_flag[s]) << 24) | (m_sz[s] << 10) | m_fn[s];
            default: return 0;
        endcase
    endfunction

    function automatic bit model_match(input int s);
        bit dir;
        int unsigned keep = 32'hFFFF_FFFF << m_msk[s];
        if (!bus_valid) return 0;
        dir = (m_fn[s] == 5 && !bus_write) || (m_fn[s] == 6 && bus_write) || (m_fn[s] == 7);
        return dir && ((bus_addr & keep) == m_cmp[s]);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: check read data before the edge, update model, check outputs.
    task automatic cyc(input string tag);
        bit [NS-1:0] mv;
        int s, r;
        #1;
        check(reg_rdata == model_read(int'(reg_addr)), tag, "reg_rdata",
              reg_rdata, model_read(int'(reg_addr)));
        for (int i = 0; i < NS; i++) mv[i] = model_match(i);
        s = int'(reg_addr) / 4;
        r = int'(reg_addr) % 4;
        @(posedge clk);
        for (int i = 0; i < NS; i++) begin
            if (mv[i]) m_flag[i] = 1;
            else if (reg_rd && r == 2 && s == i) m_flag[i] = 0;
        end
        if (reg_wr && s < NS) begin
            case (r)
                0: m_cmp[s] = reg_wdata;
                1: m_msk[s] = reg_wdata[3:0];
                2: begin
                    m_fn[s] = reg_wdata[3:0];
                    if (reg_wdata[11:10] != 2'b11) m_sz[s] = reg_wdata[11:10];
                end
                default: ;
            endcase
        end
        m_hit = mv;
        m_ev  = |mv;
        #1;
        check(hit_vec == m_hit, tag, "hit_vec", hit_vec, m_hit);
        check(dbg_event == m_ev, tag, "dbg_event", dbg_event, m_ev);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        bus_valid = 0; bus_write = 0; bus_addr = '0;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic wreg(input int s, input int r, input int unsigned d, input string tag);
        reg_wr = 1; reg_addr = RW'(s * 4 + r); reg_wdata = d;
        cyc(tag); idle_inputs();
    endtask

    task automatic rreg(input int s, input int r, input string tag);
        reg_rd = 1; reg_addr = RW'(s * 4 + r);
        cyc(tag); idle_inputs();
    endtask

    task automatic acc(input int unsigned a, input bit w, input string tag);
        bus_valid = 1; bus_write = w; bus_addr = a;
        cyc(tag); idle_inputs();
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: every register reads its reset value.
        for (int a = 0; a < NS * 4; a++) rreg(a / 4, a % 4, "R10");

        // R11: compare and mask read back.
        wreg(0, 0, 32'h2000_0040, "R11");
        wreg(0, 1, 32'hFFFF_FFF4, "R11");
        rreg(0, 0, "R11");
        rreg(0, 1, "R11");
        // R8: size word, function both directions.
        wreg(0, 2, 32'h0000_0807, "R8");
        rreg(0, 2, "R8");
        // R1: masked match inside and outside the window.
        acc(32'h2000_004C, 0, "R1");
        acc(32'h2000_0050, 1, "R1");
        acc(32'h2000_0040, 1, "R1");
        // R7: idle cycle drops the event.
        cyc("R7");

        // R2: direction codes on slots 1..3.
        wreg(1, 0, 32'h1000_0000, "R2");
        wreg(1, 2, 32'h0000_0005, "R2");
        wreg(2, 0, 32'h1000_0000, "R2");
        wreg(2, 2, 32'h0000_0006, "R2");
        wreg(3, 0, 32'h1000_0000, "R2");
        wreg(3, 2, 32'h0000_0003, "R2");
        acc(32'h1000_0000, 0, "R2");
        acc(32'h1000_0000, 1, "R2");
        acc(32'h1000_0001, 0, "R2");
        // R3: valid low with a matching address.
        bus_valid = 0; bus_write = 0; bus_addr = 32'h1000_0000;
        cyc("R3"); idle_inputs();

        // R4, R5: flags held, then cleared by read.
        for (int s = 0; s < NS; s++) rreg(s, 2, "R4");
        for (int s = 0; s < NS; s++) rreg(s, 2, "R5");

        // R6: fire and read slot 0 in the same cycle.
        bus_valid = 1; bus_write = 0; bus_addr = 32'h2000_0041;
        reg_rd = 1; reg_addr = RW'(2);
        cyc("R6"); idle_inputs();
        rreg(0, 2, "R6");
        rreg(0, 2, "R6");

        // R8: forbidden size keeps old size, code updates.
        wreg(0, 2, 32'h0000_0C06, "R8");
        rreg(0, 2, "R8");
        // R9: reserved select write ignored; high bits read 0.
        wreg(1, 3, 32'hFFFF_FFFF, "R9");
        rreg(1, 3, "R9");
        wreg(1, 2, 32'hFFFF_F5F5, "R9");
        rreg(1, 2, "R9");

        // R1: compare with bits below the mask never matches; mask 15 and 0.
        wreg(2, 0, 32'h0000_8003, "R1");
        wreg(2, 1, 32'h0000_0004, "R1");
        wreg(2, 2, 32'h0000_0007, "R1");
        acc(32'h0000_8003, 0, "R1");
        wreg(3, 0, 32'hABCD_8000, "R1");
        wreg(3, 1, 32'h0000_000F, "R1");
        wreg(3, 2, 32'h0000_0007, "R1");
        acc(32'hABCD_FFFF, 1, "R1");
        acc(32'hABCC_FFFF, 1, "R1");
        // R7: back-to-back hits, several slots.
        for (int k = 0; k < 200; k++) begin
            int unsigned base = (k % 2) ? 32'hABCD_8000 : 32'h2000_0040;
            acc(base + ($urandom % 32), $urandom % 2, "R7");
        end
        rreg(3, 2, "R5");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule